// File: doc/BRIEF.md
# ADC Oversampling Accumulator

This block takes the stream of 12-bit results from an analog-to-digital converter and averages it in hardware before it reaches the data register. When averaging is on, it adds up a batch of consecutive samples. The batch length is a power of two chosen by a 3-bit ratio code. It then divides the sum by a right shift of 0 to 8 bits, chosen by a 4-bit shift code, and rounds to nearest using the bits the shift drops. The lowest 16 bits of the result are emitted with a one-cycle valid pulse. The block has no general divider, so the shift and the ratio are set independently. A shift smaller than the ratio gives extra resolution, and an equal shift gives a plain mean.

When averaging is off, every sample is passed straight to the output, zero-extended to 16 bits, with its own valid pulse. The ratio and shift codes are captured when the first sample of a batch arrives. Turning averaging off discards any batch in progress.

Top module: `ovs_accum`

## Requirements
- R1: While reset is held and on the first cycle after it, `resultValid` is 0 and `resultData` is 0.
- R2: With `ovsEnable` low, every sample accepted on a clock edge appears on `resultData`, zero-extended to 16 bits, with `resultValid` high on the following cycle.
- R3: With `ovsEnable` high, ratio code k makes a batch of 2^(k+1) accepted samples (code 0 gives 2, code 7 gives 256). Exactly one `resultValid` pulse follows each completed batch, on the cycle after its last sample.
- R4: The emitted value is (sum + 2^(s-1)) >> s for a shift s greater than 0, and the plain sum when s is 0.
- R5: Shift codes 9 to 15 behave exactly like shift code 8.
- R6: Only the 16 least significant bits of the shifted and rounded value are emitted. For example, 256 samples of 4095 with shift 0 give 65280.
- R7: Cycles with `sampleValid` low add nothing to a batch, and they are followed by `resultValid` low.
- R8: Lowering `ovsEnable` discards a partial batch. The first sample after re-enabling starts a new batch with a zero sum.
- R9: Changes to `ovsRatio` or `ovsShift` in the middle of a batch have no effect until the next batch. Both codes are taken from the cycle of the batch's first sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | A conversion sample is present this cycle |
| sampleData | input | 12 | Conversion sample |
| ovsEnable | input | 1 | Averaging on (1) or raw pass-through (0) |
| ovsRatio | input | 3 | Batch length code, 2^(code+1) samples |
| ovsShift | input | 4 | Right-shift amount, values above 8 act as 8 |
| resultData | output | 16 | Averaged or passed-through result, held between pulses |
| resultValid | output | 1 | One-cycle strobe for a new result |

## Verification
The bench sends small sums whose odd low bits separate round-to-nearest from truncation, for example 1+2 with shift 1. It also sends all-ones batches at ratio 7, whose sum overflows 16 bits and exposes a missing truncation or wrong carry handling. Pseudo-random samples with idle gaps check that idle cycles are not counted as samples. Some batches change the ratio or shift mid-batch, and some drop the enable mid-batch, which separates configuration captured at batch start from configuration read live, and an aborted batch from one that carries over. Pass-through runs that include 0 and 4095 confirm the zero extension and the one-cycle latency.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  typedef struct packed {
    logic clearAcc;
    logic addSample;
    logic emitAvg;
    logic passRaw;
  } ovsStrobe_t;
endpackage

// File: rtl/ovs_ctrl.sv
module ovs_ctrl
  import ovs_pkg::*;
#(
  parameter int RATIO_W   = 3,
  parameter int SHIFT_W   = 4,
  parameter int MAX_SHIFT = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sampleValid,
  input  logic               ovsEnable,
  input  logic [RATIO_W-1:0] ovsRatio,
  input  logic [SHIFT_W-1:0] ovsShift,
  output ovsStrobe_t         strobe,
  output logic [SHIFT_W-1:0] shiftAmt
);
  localparam int CNT_W = 1 << RATIO_W;

  logic [CNT_W-1:0]   cnt;
  logic [RATIO_W-1:0] ratioHeld;
  logic [SHIFT_W-1:0] shiftHeld;
  logic               batchStart;
  logic [RATIO_W-1:0] activeRatio;
  logic [CNT_W:0]     batchLen;
  logic [CNT_W:0]     lastIdx;
  logic               atLast;
  logic               take;

  always_comb begin
    batchStart  = (cnt == '0);
    activeRatio = batchStart ? ovsRatio : ratioHeld;
    batchLen    = (CNT_W+1)'(2) << activeRatio;
    lastIdx     = batchLen - (CNT_W+1)'(1);
    take        = sampleValid && ovsEnable;
    atLast      = take && (cnt == lastIdx[CNT_W-1:0]);
    strobe.passRaw   = sampleValid && !ovsEnable;
    strobe.addSample = take;
    strobe.emitAvg   = atLast;
    strobe.clearAcc  = !ovsEnable || atLast;
    shiftAmt = (shiftHeld > SHIFT_W'(MAX_SHIFT)) ? SHIFT_W'(MAX_SHIFT) : shiftHeld;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      ratioHeld <= '0;
      shiftHeld <= '0;
    end else begin
      if (take && batchStart) begin
        ratioHeld <= ovsRatio;
        shiftHeld <= ovsShift;
      end
      if (!ovsEnable)  cnt <= '0;
      else if (take)   cnt <= atLast ? '0 : cnt + 1'b1;
    end
  end

  // R8: dropping the enable leaves no partial count behind
  a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rstN)
    !ovsEnable |=> (cnt == '0));

  // R9: captured shift stays fixed while a batch is under way
  a_r9_shift_held: assert property (@(posedge clk) disable iff (!rstN)
    (take && !batchStart) |=> $stable(shiftHeld));
endmodule

// File: rtl/ovs_datapath.sv
module ovs_datapath
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int ACC_W    = 20,
  parameter int SHIFT_W  = 4,
  parameter int OUT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  ovsStrobe_t          strobe,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SHIFT_W-1:0]  shiftAmt,
  output logic [OUT_W-1:0]    resultData,
  output logic                resultValid
);
  localparam int RND_W = ACC_W + 1;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sumNext;
  logic [RND_W-1:0] roundBias;
  logic [RND_W-1:0] rounded;
  logic [RND_W-1:0] shifted;
  logic [OUT_W-1:0] avgOut;
  logic [OUT_W-1:0] rawOut;

  generate
    if (OUT_W >= SAMPLE_W) begin : g_ext
      assign rawOut = OUT_W'(sampleData);
    end else begin : g_cut
      assign rawOut = sampleData[OUT_W-1:0];
    end
  endgenerate

  always_comb begin
    sumNext   = acc + ACC_W'(sampleData);
    roundBias = (shiftAmt == '0) ? '0 : (RND_W'(1) << (shiftAmt - 1'b1));
    rounded   = {1'b0, sumNext} + roundBias;
    shifted   = rounded >> shiftAmt;
    avgOut    = shifted[OUT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc         <= '0;
      resultData  <= '0;
      resultValid <= 1'b0;
    end else begin
      if (strobe.clearAcc)       acc <= '0;
      else if (strobe.addSample) acc <= sumNext;

      resultValid <= strobe.passRaw || strobe.emitAvg;
      if (strobe.passRaw)      resultData <= rawOut;
      else if (strobe.emitAvg) resultData <= avgOut;
    end
  end

  // R3: a batch-complete strobe always leaves the accumulator empty
  a_r3_acc_restart: assert property (@(posedge clk) disable iff (!rstN)
    strobe.emitAvg |=> (acc == '0));
endmodule

// File: rtl/ovs_accum.sv
module ovs_accum
  import ovs_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int RATIO_W   = 3,
  parameter int SHIFT_W   = 4,
  parameter int MAX_SHIFT = 8,
  parameter int OUT_W     = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                ovsEnable,
  input  logic [RATIO_W-1:0]  ovsRatio,
  input  logic [SHIFT_W-1:0]  ovsShift,
  output logic [OUT_W-1:0]    resultData,
  output logic                resultValid
);
  localparam int ACC_W = SAMPLE_W + (1 << RATIO_W);

  ovsStrobe_t          strobe;
  logic [SHIFT_W-1:0]  shiftAmt;

  ovs_ctrl #(
    .RATIO_W(RATIO_W), .SHIFT_W(SHIFT_W), .MAX_SHIFT(MAX_SHIFT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .ovsEnable(ovsEnable),
    .ovsRatio(ovsRatio), .ovsShift(ovsShift), .strobe(strobe), .shiftAmt(shiftAmt)
  );

  ovs_datapath #(
    .SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .SHIFT_W(SHIFT_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sampleData(sampleData),
    .shiftAmt(shiftAmt), .resultData(resultData), .resultValid(resultValid)
  );

  // R2: pass-through sample shows up zero-extended one cycle later
  a_r2_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && !ovsEnable) |=>
      (resultValid && resultData == OUT_W'($past(sampleData))));

  // R7: no result without a sample on the previous edge
  a_r7_no_idle_valid: assert property (@(posedge clk) disable iff (!rstN)
    !sampleValid |=> !resultValid);
endmodule

// File: tb/ovs_accum_test.sv
module ovs_accum_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleValid = 1'b0;
  logic [11:0] sampleData = '0;
  logic        ovsEnable = 1'b0;
  logic [2:0]  ovsRatio = '0;
  logic [3:0]  ovsShift = '0;
  logic [15:0] resultData;
  logic        resultValid;

  int    testsRun = 0;
  int    testsFailed = 0;
  int    cycles = 0;
  string curReq = "R1";
  logic [31:0] seed = 32'h1234_5678;

  // reference model state
  int mCnt = 0, mSum = 0, mRatio = 0, mShift = 0;
  bit expV = 0;
  int expD = 0;

  ovs_accum uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .ovsEnable(ovsEnable), .ovsRatio(ovsRatio), .ovsShift(ovsShift),
    .resultData(resultData), .resultValid(resultValid)
  );

  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp_);
    testsRun++;
    if (act != exp_) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp_, $time);
    end
  endtask

  // behavioural reference, compared on every clock
  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mCnt = 0; mSum = 0; expV = 0;
    end else begin
      expV = 0;
      if (sampleValid && !ovsEnable) begin
        expV = 1; expD = sampleData; mCnt = 0; mSum = 0;
      end else if (sampleValid) begin
        if (mCnt == 0) begin mRatio = ovsRatio; mShift = ovsShift; end
        mSum += sampleData;
        mCnt++;
        if (mCnt == (2 << mRatio)) begin
          int s;
          s = (mShift > 8) ? 8 : mShift;
          expD = ((s == 0) ? mSum : ((mSum + (1 << (s - 1))) >> s)) & 16'hFFFF;
          expV = 1; mCnt = 0; mSum = 0;
        end
      end else if (!ovsEnable) begin
        mCnt = 0; mSum = 0;
      end
      #2;
      check(curReq, resultValid, expV);
      if (expV) check(curReq, resultData, expD);
    end
  end

  task automatic send(int v);
    @(negedge clk);
    sampleValid = 1'b1; sampleData = 12'(v);
    @(negedge clk);
    sampleValid = 1'b0;
  endtask

  task automatic sendBurst(int v);
    @(negedge clk);
    sampleValid = 1'b1; sampleData = 12'(v);
  endtask

  task automatic idle(int n);
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[27:16]);
  endfunction

  task automatic cfg(bit en, int r, int s);
    @(negedge clk);
    ovsEnable = en; ovsRatio = 3'(r); ovsShift = 4'(s);
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1", resultValid, 0);
    check("R1", resultData, 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #2;
    check("R1", resultValid, 0);
    check("R1", resultData, 0);

    // R2: pass-through
    curReq = "R2";
    cfg(0, 0, 0);
    sendBurst(0); sendBurst(4095); sendBurst(1); sendBurst(2048);
    idle(2);
    send(1234);

    // R4: rounding, 1+2 shift 1 -> 2 (truncation would give 1)
    curReq = "R4";
    cfg(1, 0, 1);
    send(1); send(2);
    cfg(1, 0, 0);
    send(100); send(7);
    cfg(1, 2, 3);
    for (int i = 0; i < 8; i++) sendBurst(i * 511 + 3);
    idle(2);

    // R3: batch lengths across ratio codes with random data
    curReq = "R3";
    for (int r = 0; r < 8; r++) begin
      cfg(1, r, r + 1);
      for (int i = 0; i < (2 << r); i++) sendBurst(rnd());
      idle(1);
    end

    // R5: shift codes above 8
    curReq = "R5";
    for (int s = 9; s < 16; s += 3) begin
      cfg(1, 3, s);
      for (int i = 0; i < 16; i++) sendBurst(4095);
      idle(1);
    end

    // R6: truncation to 16 bits
    curReq = "R6";
    cfg(1, 7, 0);
    for (int i = 0; i < 256; i++) sendBurst(4095);
    cfg(1, 7, 4);
    for (int i = 0; i < 256; i++) sendBurst(4095);
    idle(2);

    // R7: idle gaps inside a batch
    curReq = "R7";
    cfg(1, 2, 2);
    for (int i = 0; i < 16; i++) begin
      send(rnd());
      if (i % 3 == 0) idle(i % 4 + 1);
    end

    // R8: abort a partial batch
    curReq = "R8";
    cfg(1, 2, 0);
    send(4000); send(4000); send(4000);
    cfg(0, 2, 0);
    idle(1);
    cfg(1, 2, 0);
    for (int i = 0; i < 8; i++) send(10 + i);

    // R9: mid-batch config change ignored
    curReq = "R9";
    cfg(1, 1, 0);
    send(5); send(6);
    cfg(1, 5, 3);
    send(7); send(8);
    for (int i = 0; i < 64; i++) sendBurst(rnd());
    idle(3);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    testsRun++; testsFailed++;
    $display("FAIL watchdog: actual %0d expected <100000 cycles", cycles);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule